// File: doc/BRIEF.md
# Input-locked display timing generator with border and active windows

This block produces output raster timing for a display path whose frame rate follows an incoming video stream. It runs two counters on the output pixel enable: a pixel counter across the line and a line counter down the frame. From these counters it drives horizontal and vertical sync, a border window, and an active window that sits inside the border. The horizontal layout is set by four lengths: sync, back porch, active and front porch. Two border widths, low side and high side, shrink the active window relative to the border. The vertical axis is set up the same way in lines.

The output frame does not free-run. A small tracker counts input pixels and input lines from the edges of the input syncs. When the input position reaches a programmed line and pixel, a frame-start request is raised. The next output pixel enable restarts the output counters at pixel 0, line 0, wherever they were. Software picks that position so the output back porch finishes a few input lines after the input back porch does. All timing fields are shadowed and are copied only at an output frame boundary.

Top module: `bordered_timing_gen`

## Requirements
- R1: After reset, and until the first frame-start request is consumed, hsync_o, vsync_o, border_de_o and active_de_o are 0 and x_o and y_o are 0.
- R2: The input tracker looks at input pixels on cycles where in_pix_en_i is 1. A pixel where in_vsync_i is 1 and was 0 on the previous input pixel gets position (line 0, pixel 0). Otherwise, a pixel where in_hsync_i rises gets pixel 0 and the line count plus one. Any other input pixel gets the pixel count plus one. When a pixel's position equals (cfg_start_line_i, cfg_start_pix_i), a frame-start request is raised. The next cycle with out_pix_en_i set x_o and y_o to 0 and starts output.
- R3: Once started, each out_pix_en_i cycle advances x_o. When x_o reaches htotal-1 it returns to 0 and y_o advances. When y_o reaches vtotal-1 as well, y_o also returns to 0. Here htotal = h_sync+h_bp+h_act+h_fp, and vtotal is formed the same way. Without out_pix_en_i the counters hold.
- R4: hsync_o is 1 exactly when x_o < h_sync. vsync_o is 1 exactly when y_o < v_sync.
- R5: border_de_o is 1 exactly when x_o lies in [h_sync+h_bp, h_sync+h_bp+h_act) and y_o lies in the vertical range built the same way. The end count is excluded.
- R6: active_de_o uses the border ranges, with the start raised by the low-side border and the end lowered by the high-side border, on both axes. With all four borders 0 it equals border_de_o.
- R7: A change to any cfg timing input has no effect on the outputs until the next frame boundary. A frame boundary is the wrap to (0,0) or a consumed frame-start request. From that boundary on, the new values apply.
- R8: A frame-start request consumed while output is already running restarts the counters at (0,0) from any position. It takes priority over the normal wrap.
- R9: A frame-start request stays pending for any number of cycles without out_pix_en_i. It is consumed by the first out_pix_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_pix_en_i | input | 1 | Input pixel strobe |
| in_hsync_i | input | 1 | Input line sync |
| in_vsync_i | input | 1 | Input frame sync |
| out_pix_en_i | input | 1 | Output pixel strobe |
| cfg_h_sync_i | input | 12 | Horizontal sync length |
| cfg_h_bp_i | input | 12 | Horizontal back porch |
| cfg_h_act_i | input | 12 | Horizontal border-window width |
| cfg_h_fp_i | input | 12 | Horizontal front porch |
| cfg_h_bor_lo_i | input | 12 | Left border inside the window |
| cfg_h_bor_hi_i | input | 12 | Right border inside the window |
| cfg_v_sync_i | input | 12 | Vertical sync length in lines |
| cfg_v_bp_i | input | 12 | Vertical back porch |
| cfg_v_act_i | input | 12 | Vertical border-window height |
| cfg_v_fp_i | input | 12 | Vertical front porch |
| cfg_v_bor_lo_i | input | 12 | Top border inside the window |
| cfg_v_bor_hi_i | input | 12 | Bottom border inside the window |
| cfg_start_line_i | input | 12 | Input line of output frame start |
| cfg_start_pix_i | input | 12 | Input pixel of output frame start |
| hsync_o | output | 1 | Output horizontal sync |
| vsync_o | output | 1 | Output vertical sync |
| border_de_o | output | 1 | Border window enable |
| active_de_o | output | 1 | Active window enable |
| x_o | output | 12 | Output pixel counter |
| y_o | output | 12 | Output line counter |

## Verification
Every output is decoded from registers, so a counter step, lock or shadow copy shows up on the outputs one clock edge after the out_pix_en_i edge that caused it. A frame start appears one enabled output pixel after the clock on which the matching input pixel was taken in. The bench keeps a behavioural model that is advanced on the same rising edge. It compares all six outputs at the falling edge that follows, so each result is checked in the cycle it becomes due. Requests that are held pending and configuration writes made mid-frame are checked in the same way.

// File: rtl/bt_pkg.sv
package bt_pkg;
  parameter int unsigned CNT_W  = 12;
  parameter int unsigned N_AXES = 2;
  localparam int unsigned AX_H = 0;
  localparam int unsigned AX_V = 1;

  typedef struct packed {
    logic [CNT_W-1:0] sync;
    logic [CNT_W-1:0] bp;
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] fp;
    logic [CNT_W-1:0] bor_lo;
    logic [CNT_W-1:0] bor_hi;
  } axis_cfg_t;

  typedef struct packed {
    logic sync;
    logic border;
    logic active;
    logic last;
  } axis_flags_t;
endpackage

// File: rtl/bt_in_tracker.sv
module bt_in_tracker
  import bt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pix_en_i,
  input  logic         hs_i,
  input  logic         vs_i,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] pix_i,
  output logic         hit_o
);
  logic [W-1:0] x_q, y_q, x_d, y_d;
  logic         hs_q, vs_q;

  always_comb begin
    x_d = x_q + 1'b1;
    y_d = y_q;
    if (vs_i && !vs_q) begin
      x_d = '0;
      y_d = '0;
    end else if (hs_i && !hs_q) begin
      x_d = '0;
      y_d = y_q + 1'b1;
    end
  end

  assign hit_o = pix_en_i && (x_d == pix_i) && (y_d == line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q  <= '0;
      y_q  <= '0;
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else if (pix_en_i) begin
      x_q  <= x_d;
      y_q  <= y_d;
      hs_q <= hs_i;
      vs_q <= vs_i;
    end
  end

  // line start always lands on pixel 0
  p_line_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && hs_i && !hs_q) |=> (x_q == '0));
endmodule

// File: rtl/bt_axis_win.sv
module bt_axis_win
  import bt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  axis_cfg_t    cfg_i,
  input  logic [W-1:0] cnt_i,
  output axis_flags_t  flags_o
);
  logic [W-1:0] bor_st, bor_end, act_st, act_end, total;

  always_comb begin
    bor_st  = cfg_i.sync + cfg_i.bp;
    bor_end = bor_st + cfg_i.act;
    act_st  = bor_st + cfg_i.bor_lo;
    act_end = bor_end - cfg_i.bor_hi;
    total   = bor_end + cfg_i.fp;
    flags_o.sync   = cnt_i < cfg_i.sync;
    flags_o.border = (cnt_i >= bor_st) && (cnt_i < bor_end);
    flags_o.active = (cnt_i >= act_st) && (cnt_i < act_end);
    flags_o.last   = cnt_i == (total - 1'b1);
  end
endmodule

// File: rtl/bt_out_seq.sv
module bt_out_seq
  import bt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         hit_i,
  input  axis_cfg_t [N_AXES-1:0]       cfg_i,
  input  logic [N_AXES-1:0]            last_i,
  output axis_cfg_t [N_AXES-1:0]       shadow_o,
  output logic [N_AXES-1:0][W-1:0]     cnt_o,
  output logic                         locked_o
);
  logic                     pend_q, locked_q;
  logic [N_AXES-1:0][W-1:0] cnt_q;
  axis_cfg_t [N_AXES-1:0]   shadow_q;
  logic                     start, step, wrap;

  assign start = en_i && pend_q;
  assign step  = en_i && locked_q && !pend_q;
  assign wrap  = step && (&last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      locked_q <= 1'b0;
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      pend_q <= hit_i || (pend_q && !en_i);
      if (start) begin
        locked_q <= 1'b1;
        cnt_q    <= '0;
        shadow_q <= cfg_i;
      end else if (step) begin
        if (last_i[AX_H]) begin
          cnt_q[AX_H] <= '0;
          cnt_q[AX_V] <= last_i[AX_V] ? '0 : cnt_q[AX_V] + 1'b1;
        end else begin
          cnt_q[AX_H] <= cnt_q[AX_H] + 1'b1;
        end
        if (wrap) shadow_q <= cfg_i;
      end
    end
  end

  assign shadow_o = shadow_q;
  assign cnt_o    = cnt_q;
  assign locked_o = locked_q;

  p_idle_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_q |-> (cnt_q == '0));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  p_resync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && pend_q) |=> (cnt_q == '0 && locked_q));
  p_pend_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !en_i) |=> pend_q);
  p_shadow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> $stable(shadow_q));
endmodule

// File: rtl/bordered_timing_gen.sv
module bordered_timing_gen
  import bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_pix_en_i,
  input  logic             in_hsync_i,
  input  logic             in_vsync_i,
  input  logic             out_pix_en_i,
  input  logic [CNT_W-1:0] cfg_h_sync_i,
  input  logic [CNT_W-1:0] cfg_h_bp_i,
  input  logic [CNT_W-1:0] cfg_h_act_i,
  input  logic [CNT_W-1:0] cfg_h_fp_i,
  input  logic [CNT_W-1:0] cfg_h_bor_lo_i,
  input  logic [CNT_W-1:0] cfg_h_bor_hi_i,
  input  logic [CNT_W-1:0] cfg_v_sync_i,
  input  logic [CNT_W-1:0] cfg_v_bp_i,
  input  logic [CNT_W-1:0] cfg_v_act_i,
  input  logic [CNT_W-1:0] cfg_v_fp_i,
  input  logic [CNT_W-1:0] cfg_v_bor_lo_i,
  input  logic [CNT_W-1:0] cfg_v_bor_hi_i,
  input  logic [CNT_W-1:0] cfg_start_line_i,
  input  logic [CNT_W-1:0] cfg_start_pix_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             border_de_o,
  output logic             active_de_o,
  output logic [CNT_W-1:0] x_o,
  output logic [CNT_W-1:0] y_o
);
  axis_cfg_t   [N_AXES-1:0]            cfg, shadow;
  axis_flags_t [N_AXES-1:0]            flags;
  logic        [N_AXES-1:0][CNT_W-1:0] cnt;
  logic        [N_AXES-1:0]            last;
  logic                                hit, locked;

  assign cfg[AX_H] = '{sync: cfg_h_sync_i, bp: cfg_h_bp_i, act: cfg_h_act_i,
                       fp: cfg_h_fp_i, bor_lo: cfg_h_bor_lo_i, bor_hi: cfg_h_bor_hi_i};
  assign cfg[AX_V] = '{sync: cfg_v_sync_i, bp: cfg_v_bp_i, act: cfg_v_act_i,
                       fp: cfg_v_fp_i, bor_lo: cfg_v_bor_lo_i, bor_hi: cfg_v_bor_hi_i};

  bt_in_tracker #(.W(CNT_W)) u_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pix_en_i (in_pix_en_i),
    .hs_i     (in_hsync_i),
    .vs_i     (in_vsync_i),
    .line_i   (cfg_start_line_i),
    .pix_i    (cfg_start_pix_i),
    .hit_o    (hit)
  );

  bt_out_seq #(.W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (out_pix_en_i),
    .hit_i    (hit),
    .cfg_i    (cfg),
    .last_i   (last),
    .shadow_o (shadow),
    .cnt_o    (cnt),
    .locked_o (locked)
  );

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    bt_axis_win #(.W(CNT_W)) u_win (
      .cfg_i   (shadow[a]),
      .cnt_i   (cnt[a]),
      .flags_o (flags[a])
    );
    assign last[a] = flags[a].last;
  end

  assign hsync_o     = locked && flags[AX_H].sync;
  assign vsync_o     = locked && flags[AX_V].sync;
  assign border_de_o = locked && flags[AX_H].border && flags[AX_V].border;
  assign active_de_o = locked && flags[AX_H].active && flags[AX_V].active;
  assign x_o         = cnt[AX_H];
  assign y_o         = cnt[AX_V];

  p_sync_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> (x_o == '0));
  p_border_after_sync_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    border_de_o |-> !hsync_o);
endmodule

// File: tb/bordered_timing_gen_test.sv
module bordered_timing_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_en = 1'b1, in_hs = 1'b0, in_vs = 1'b0, out_en = 1'b0;
  logic hs_o, vs_o, bde_o, ade_o;
  logic [11:0] x_o, y_o;
  int c [14];
  int n_chk = 0, n_err = 0;
  string phase = "R3";
  bit hold = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bordered_timing_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .in_pix_en_i(in_en), .in_hsync_i(in_hs),
    .in_vsync_i(in_vs), .out_pix_en_i(out_en),
    .cfg_h_sync_i(12'(c[0])), .cfg_h_bp_i(12'(c[1])), .cfg_h_act_i(12'(c[2])),
    .cfg_h_fp_i(12'(c[3])), .cfg_h_bor_lo_i(12'(c[4])), .cfg_h_bor_hi_i(12'(c[5])),
    .cfg_v_sync_i(12'(c[6])), .cfg_v_bp_i(12'(c[7])), .cfg_v_act_i(12'(c[8])),
    .cfg_v_fp_i(12'(c[9])), .cfg_v_bor_lo_i(12'(c[10])), .cfg_v_bor_hi_i(12'(c[11])),
    .cfg_start_line_i(12'(c[12])), .cfg_start_pix_i(12'(c[13])),
    .hsync_o(hs_o), .vsync_o(vs_o), .border_de_o(bde_o), .active_de_o(ade_o),
    .x_o(x_o), .y_o(y_o)
  );

  // reference model state
  int sh [12];
  int mx, my, ix, iy;
  bit m_lock, m_pend, hs_p, vs_p, ev_lock, ev_relock;

  always @(posedge clk) begin
    bit hit;
    if (!rst_n) begin
      mx = 0; my = 0; ix = 0; iy = 0;
      m_lock = 0; m_pend = 0; hs_p = 0; vs_p = 0;
      ev_lock = 0; ev_relock = 0;
      foreach (sh[k]) sh[k] = 0;
    end else begin
      ev_lock = 0; ev_relock = 0;
      if (out_en) begin
        if (m_pend) begin
          ev_lock = 1; ev_relock = m_lock;
          mx = 0; my = 0; m_lock = 1;
          for (int k = 0; k < 12; k++) sh[k] = c[k];
        end else if (m_lock) begin
          if (mx == sh[0] + sh[1] + sh[2] + sh[3] - 1) begin
            mx = 0;
            if (my == sh[6] + sh[7] + sh[8] + sh[9] - 1) begin
              my = 0;
              for (int k = 0; k < 12; k++) sh[k] = c[k];
            end else my++;
          end else mx++;
        end
      end
      hit = 0;
      if (in_en) begin
        if (in_vs && !vs_p) begin ix = 0; iy = 0; end
        else if (in_hs && !hs_p) begin ix = 0; iy++; end
        else ix++;
        hs_p = in_hs; vs_p = in_vs;
        if (ix == c[12] && iy == c[13 - 1 + 1 - 1]) hit = 0;
        if (iy == c[12] && ix == c[13]) hit = 1;
      end
      m_pend = hit ? 1 : (out_en ? 0 : m_pend);
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit in_win(int v, int lo, int hi);
    return (v >= lo) && (v < hi);
  endfunction

  // input video source and output strobe
  int gx = 0, gy = 0, cyc = 0;
  always @(negedge clk) begin
    gx++;
    if (gx == 20) begin gx = 0; gy = (gy == 11) ? 0 : gy + 1; end
    in_hs <= (gx < 2);
    in_vs <= (gy < 2);
    cyc++;
    out_en <= !hold && (cyc % 3 != 2);
  end

  // compare outputs every cycle at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      int hbs, hbe, vbs, vbe;
      string ctag, t4, t5, t6;
      bit eb;
      hbs = sh[0] + sh[1]; hbe = hbs + sh[2];
      vbs = sh[6] + sh[7]; vbe = vbs + sh[8];
      ctag = ev_relock ? "R8" : (ev_lock ? "R2" : phase);
      t4 = m_lock ? "R4" : "R1";
      t5 = m_lock ? "R5" : "R1";
      t6 = m_lock ? "R6" : "R1";
      if (!m_lock) ctag = "R1";
      eb = m_lock && in_win(mx, hbs, hbe) && in_win(my, vbs, vbe);
      chk(ctag, int'(x_o), mx, "x");
      chk(ctag, int'(y_o), my, "y");
      chk(t4, int'(hs_o), int'(m_lock && mx < sh[0]), "hsync");
      chk(t4, int'(vs_o), int'(m_lock && my < sh[6]), "vsync");
      chk(t5, int'(bde_o), int'(eb), "border_de");
      chk(t6, int'(ade_o), int'(m_lock && in_win(mx, hbs + sh[4], hbe - sh[5])
                                 && in_win(my, vbs + sh[10], vbe - sh[11])), "active_de");
    end
  end

  initial begin
    c = '{3, 2, 8, 3, 1, 2, 1, 1, 4, 2, 1, 0, 3, 5};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    phase = "R3";
    repeat (1000) @(negedge clk);
    phase = "R7";             // mid-frame change, visible only after boundary
    c[2] = 6; c[7] = 2;
    repeat (600) @(negedge clk);
    phase = "R6";             // zero borders: active equals border
    c[4] = 0; c[5] = 0; c[10] = 0; c[11] = 0;
    repeat (600) @(negedge clk);
    phase = "R9";             // request waits through a long stall
    hold = 1'b1;
    repeat (300) @(negedge clk);
    hold = 1'b0;
    repeat (60) @(negedge clk);
    phase = "R1";             // second reset returns to idle
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule